// File: doc/BRIEF.md
# Prescaled Trigger Type Encoder

This block sits between the global trigger logic and the crate distribution links. Each clock it samples a 32-bit pattern of trigger conditions. Every condition has its own prescale ratio, so a condition that fires often is accepted only on every Nth occurrence. The conditions that survive the prescale are reduced to one 8-bit type code by fixed priority.

An accepted trigger is packed into a 16-bit distribution word together with a sync flag. It is also stamped with a 48-bit tick counter that a sync request clears. After each acceptance a short hold-off window guarantees a minimum spacing between triggers. Patterns that arrive inside the window are discarded completely.

Control is a two-state machine. `ST_READY` samples patterns. On an acceptance it takes the transition *accept* to `ST_HOLD`. `ST_HOLD` counts down the hold-off, and on the transition *expire* it returns to `ST_READY`, so the next pattern is sampled four edges after the accepting edge. Under the default parameters the word appears one cycle after the edge that samples the pattern.

Top module: `trig_type_encoder`

## Requirements
- R1: While reset is asserted and immediately after it, `dist_word` is 0 and `trig_stamp` is 0. Reset is asynchronous and active low, and it may be applied in the middle of operation.
- R2: For bit i, let P be its ratio in `prescale_cfg[16*i +: 16]`. When P is not zero, the bit survives on the Pth, 2Pth, 3Pth and later eligible occurrences counted since reset. P = 1 makes the bit survive every time.
- R3: A bit whose ratio is 0 never produces a trigger, even when it is the only bit set. A pattern made only of such bits leaves `trig_stamp` unchanged.
- R4: The type code is the index of the lowest-numbered surviving bit plus 1, so bit 0 gives 1 and bit 31 gives 32. A lower bit that is set but prescaled away does not block a higher survivor.
- R5: `dist_word` holds the type in bits [7:0], the valid flag in bit 8, the sync flag in bit 9, and zero in bits [15:10]. When no trigger is accepted, bits [8:0] are zero. The word is registered and reflects the pattern sampled at the previous clock edge.
- R6: After an acceptance at edge E, patterns sampled at edges E+1, E+2 and E+3 are ignored and their prescale counters do not advance. Edge E+4 samples normally.
- R7: A `sync_req` sampled at an edge sets bit 9 of the next word. This happens whether or not a trigger is accepted at the same edge, and also during hold-off.
- R8: The tick counter counts clock edges since reset or since the last edge that sampled `sync_req`, which sets it to 0. `trig_stamp` takes the counter value as updated at the accepting edge and holds it until the next acceptance.
- R9: A pattern that advances prescale counters but yields no survivor produces no trigger and starts no hold-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pattern | input | 32 | Trigger condition bits, sampled each edge |
| sync_req | input | 1 | Sync request: clears tick counter, flags the word |
| prescale_cfg | input | 512 | Sixteen-bit ratio per condition bit, bit i at [16*i +: 16] |
| dist_word | output | 16 | Distribution word: type, valid, sync |
| trig_stamp | output | 48 | Tick count of the latest accepted trigger |

## Verification
The word and the stamp are both due in the cycle after the edge that samples the stimulus. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge, so each table row is judged against its own sample. Hold-off effects are judged by vectors placed one, two and three rows after an acceptance, and by a later row whose outcome depends on whether a dropped pattern advanced a counter. The expected stamp comes from a bench counter that is cleared by the same sync pulses the design sees.

// File: rtl/tte_pkg.sv
package tte_pkg;
    localparam int WORD_W    = 16;
    localparam int VALID_BIT = 8;
    localparam int SYNC_BIT  = 9;
    localparam int TYPE_MSB  = 7;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_HOLD  = 1'b1
    } tte_state_e;
endpackage

// File: rtl/tte_prescale_lane.sv
module tte_prescale_lane #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [PS_W-1:0] ratio,
    output logic            pass
);
    localparam logic [PS_W-1:0] ONE = PS_W'(1);

    logic [PS_W-1:0] cnt_q;
    logic            enabled;
    logic            at_last;

    assign enabled = (ratio != '0);
    // >= keeps the lane sane if the ratio is lowered mid-count
    assign at_last = enabled && (cnt_q >= ratio - ONE);
    assign pass    = hit && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hit && enabled)
            cnt_q <= at_last ? '0 : cnt_q + ONE;
    end

    // R2: a passing occurrence restarts the count
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> (cnt_q == '0));
endmodule

// File: rtl/tte_prio_enc.sv
module tte_prio_enc #(
    parameter int N      = 32,
    parameter int CODE_W = 8
) (
    input  logic [N-1:0]      req,
    output logic              found,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        found = 1'b0;
        code  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                code  = CODE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/tte_stamp.sv
module tte_stamp #(
    parameter int TS_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [TS_W-1:0] ts_q,
    output logic [TS_W-1:0] ts_next
);
    localparam logic [TS_W-1:0] ONE = TS_W'(1);

    assign ts_next = clr ? '0 : ts_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ts_q <= '0;
        else
            ts_q <= ts_next;
    end

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ts_q == '0));
    a_r8_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (ts_q == $past(ts_q) + ONE));
endmodule

// File: rtl/trig_type_encoder.sv
module trig_type_encoder
    import tte_pkg::*;
#(
    parameter int NUM_BITS = 32,
    parameter int PS_W     = 16,
    parameter int TYPE_W   = 8,
    parameter int TS_W     = 48,
    parameter int HOLDOFF  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_BITS-1:0]      trig_pattern,
    input  logic                     sync_req,
    input  logic [NUM_BITS*PS_W-1:0] prescale_cfg,
    output logic [WORD_W-1:0]        dist_word,
    output logic [TS_W-1:0]          trig_stamp
);
    localparam int              HC_W      = $clog2(HOLDOFF + 1);
    localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(HOLDOFF - 1);
    localparam logic [HC_W-1:0] HC_ONE    = HC_W'(1);

    tte_state_e state_q, state_n;
    logic [HC_W-1:0]     hold_q, hold_n;
    logic                eligible;
    logic [NUM_BITS-1:0] survive;
    logic                found;
    logic [TYPE_W-1:0]   type_code;
    logic [TS_W-1:0]     ts_q, ts_next;
    logic [WORD_W-1:0]   word_q;
    logic [TS_W-1:0]     stamp_q;

    assign eligible = (state_q == ST_READY);

    for (genvar g = 0; g < NUM_BITS; g++) begin : g_lane
        tte_prescale_lane #(.PS_W(PS_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (eligible && trig_pattern[g]),
            .ratio (prescale_cfg[g*PS_W +: PS_W]),
            .pass  (survive[g])
        );
    end

    tte_prio_enc #(.N(NUM_BITS), .CODE_W(TYPE_W)) u_prio (
        .req   (survive),
        .found (found),
        .code  (type_code)
    );

    tte_stamp #(.TS_W(TS_W)) u_stamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sync_req),
        .ts_q    (ts_q),
        .ts_next (ts_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            hold_q  <= hold_n;
        end
    end

    // transitions: accept (READY->HOLD), expire (HOLD->READY)
    always_comb begin
        state_n = state_q;
        hold_n  = hold_q;
        unique case (state_q)
            ST_READY: begin
                if (found && (HOLDOFF > 1)) begin
                    state_n = ST_HOLD;
                    hold_n  = HOLD_LOAD;
                end
            end
            ST_HOLD: begin
                hold_n = hold_q - HC_ONE;
                if (hold_q <= HC_ONE)
                    state_n = ST_READY;
            end
            default: state_n = ST_READY;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            stamp_q <= '0;
        end else begin
            word_q           <= '0;
            word_q[SYNC_BIT] <= sync_req;
            if (found) begin
                word_q[VALID_BIT]  <= 1'b1;
                word_q[TYPE_MSB:0] <= type_code[TYPE_MSB:0];
                stamp_q            <= ts_next;
            end
        end
    end

    assign dist_word  = word_q;
    assign trig_stamp = stamp_q;

    // edges since the last valid word, saturating at HOLDOFF
    logic [HC_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= HC_W'(HOLDOFF);
        else if (word_q[VALID_BIT])
            gap_q <= HC_ONE;
        else if (gap_q < HC_W'(HOLDOFF))
            gap_q <= gap_q + HC_ONE;
    end

    a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[VALID_BIT] |-> (gap_q >= HC_W'(HOLDOFF)));
    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !word_q[VALID_BIT]);
    a_r4_type_range: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[VALID_BIT] |-> ((word_q[TYPE_MSB:0] != '0) &&
                               (32'(word_q[TYPE_MSB:0]) <= NUM_BITS)));
    a_r5_idle_type: assert property (@(posedge clk) disable iff (!rst_n)
        !word_q[VALID_BIT] |-> (word_q[TYPE_MSB:0] == '0));
    a_r7_sync_echo: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> word_q[SYNC_BIT]);
    a_r8_stamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_q[VALID_BIT] |-> $stable(stamp_q));
endmodule

// File: tb/tb_trig_type_encoder.sv
module tb_trig_type_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;

    localparam logic [31:0] PAT [NV] = '{
        32'h0, 32'h1, 32'h2, 32'h2, 32'h4, 32'h0, 32'h4, 32'h4,
        32'h0, 32'h0, 32'h0, 32'hC, 32'hC, 32'hC, 32'h0, 32'h0,
        32'h8, 32'h0, 32'h0, 32'h0, 32'h3, 32'h0, 32'h0, 32'h0,
        32'h80000000, 32'h80000002};
    localparam logic SYN [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0};
    localparam logic [15:0] EXPW [NV] = '{
        16'h000, 16'h000, 16'h102, 16'h000, 16'h000, 16'h000, 16'h000, 16'h103,
        16'h200, 16'h000, 16'h000, 16'h000, 16'h103, 16'h000, 16'h000, 16'h000,
        16'h304, 16'h000, 16'h000, 16'h000, 16'h102, 16'h000, 16'h000, 16'h000,
        16'h120, 16'h000};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  trig_pattern = '0;
    logic         sync_req = 1'b0;
    logic [511:0] prescale_cfg;
    logic [15:0]  dist_word;
    logic [47:0]  trig_stamp;
    logic [47:0]  ref_ts;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_type_encoder dut (
        .clk(clk), .rst_n(rst_n), .trig_pattern(trig_pattern),
        .sync_req(sync_req), .prescale_cfg(prescale_cfg),
        .dist_word(dist_word), .trig_stamp(trig_stamp));

    // R8 reference: edges since reset or last sync
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_ts <= '0;
        else        ref_ts <= sync_req ? '0 : ref_ts + 48'd1;
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [31:0] p, input logic s);
        trig_pattern = p;
        sync_req     = s;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) prescale_cfg[i*16 +: 16] = 16'd1;
        prescale_cfg[0*16 +: 16] = 16'd0;
        prescale_cfg[2*16 +: 16] = 16'd2;
        prescale_cfg[3*16 +: 16] = 16'd3;

        repeat (3) @(negedge clk);
        check("R1 reset word", 64'(dist_word), 64'h0);
        check("R1 reset stamp", 64'(trig_stamp), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 word after release", 64'(dist_word), 64'h0);

        // table: R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            drive(PAT[i], SYN[i]);
            check($sformatf("R2/R3/R4/R5/R6/R7/R9 vector %0d", i),
                  64'(dist_word), 64'(EXPW[i]));
            if (EXPW[i][8])
                check($sformatf("R8 stamp vector %0d", i), 64'(trig_stamp), 64'(ref_ts));
        end

        // finish hold-off, then R4 lowest surviving bit wins
        repeat (2) drive(32'h0, 1'b0);
        drive(32'h0, 1'b0);
        drive(32'h12, 1'b0);
        check("R4 bits 1 and 4 give type 2", 64'(dist_word), 64'h102);

        // R7 sync alone in ready state, then R8 stamp after sync
        repeat (4) drive(32'h0, 1'b0);
        drive(32'h0, 1'b1);
        check("R7 sync flag alone", 64'(dist_word), 64'h200);
        repeat (5) drive(32'h0, 1'b0);
        drive(32'h10, 1'b0);
        check("R5 type 5 word", 64'(dist_word), 64'h105);
        check("R8 stamp six edges after sync", 64'(trig_stamp), 64'd6);
        check("R8 stamp vs reference", 64'(trig_stamp), 64'(ref_ts));

        // R3 disabled bit alone leaves stamp untouched
        repeat (4) drive(32'h0, 1'b0);
        drive(32'h1, 1'b0);
        check("R3 disabled bit word", 64'(dist_word), 64'h0);
        check("R3 stamp unchanged", 64'(trig_stamp), 64'd6);

        // R1 reset in mid-run
        drive(32'h2, 1'b0);
        check("R1 pre-reset accept", 64'(dist_word), 64'h102);
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset word", 64'(dist_word), 64'h0);
        check("R1 mid-run reset stamp", 64'(trig_stamp), 64'h0);
        trig_pattern = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule